// File: doc/BRIEF.md
# Guarded Configuration Register Write Sequencer

This block protects a small nonvolatile configuration register that holds a watchdog interval select, a power-up delay select and a block-protect flag. It watches an abstracted serial-bus transaction stream made of start and stop markers, a read/write flag taken with each start, and a stream of data bytes. A new configuration can only be written after two single-byte unlock transactions. The first (02h) arms a write-enable latch. The second (06h) arms a register-write-enable latch. A third transaction then supplies the commit byte.

Each data byte of a write transaction gets an ACK or NACK one cycle after it arrives. A commit takes effect at the stop marker. It then holds a busy flag for a programmable number of cycles, which stands in for the nonvolatile programming time. While busy is high, new transactions are refused. When busy drops, both enable latches clear, so the full unlock sequence is needed again. A pulse on a protection-violation input withdraws the register-write enable.

Top module: `ctl_reg_guard`

## Requirements
- R1: After reset the power-up select is 01, the watchdog select is 11, block-protect is 0, both enable latches are 0, busy is 0 and no ACK response is pending.
- R2: A write transaction made of the single byte 02h, closed by stop, sets the write-enable latch and does not raise busy.
- R3: A single-byte write of exactly 06h sets the register-write enable only while the write-enable latch is already set. Byte 06h without write enable, and any other byte such as 07h, leaves the register-write enable at 0.
- R4: With the register-write enable set, a single-byte write whose bits 3..1 equal 001 commits at its stop marker and not before. Power-up select becomes {bit7, bit0}, watchdog select becomes bits 6..5, and block-protect becomes bit 4.
- R5: After a commit stop, busy is high for exactly PROG_TICKS cycles. Both enable latches read 0 when busy falls.
- R6: With the register-write enable set, a commit byte whose bits 3..1 equal 011 (for example 06h or F6h) leaves all fields and both latches unchanged and does not raise busy.
- R7: The first data byte of an accepted write transaction is answered with ACK=1 on ack_valid in the cycle after the byte. Every further byte in that transaction gets ACK=0, and the transaction then has no effect.
- R8: Read transactions produce no ack_valid and do not disturb either latch, so an unlock sequence survives reads placed between its steps.
- R9: A pulse on prot_hit clears the register-write enable and leaves the write-enable latch set.
- R10: Every byte of a transaction that starts while busy is high is answered with ACK=0. Such a transaction has no effect, even if its stop arrives after busy has fallen.
- R11: The byte sequence 02h, 06h, 02h sets all three fields to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Start marker pulse, opens a transaction |
| txn_stop | input | 1 | Stop marker pulse, closes a transaction |
| txn_read | input | 1 | Read flag, sampled with txn_start |
| byte_valid | input | 1 | A data byte is present this cycle |
| byte_data | input | 8 | Data byte |
| prot_hit | input | 1 | Pulse: write attempted to a protected block |
| ack_valid | output | 1 | ACK response present this cycle |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| busy | output | 1 | Emulated nonvolatile programming in progress |
| pup_sel | output | 2 | Stored power-up delay select |
| wdog_sel | output | 2 | Stored watchdog interval select |
| bprot | output | 1 | Stored block-protect flag |

## Verification
The assertions assume a well-formed marker stream. Start and stop never share a cycle. A data byte never coincides with either marker. Busy can only rise at a stop, so no accepted transaction is ever open while busy is high. The bench respects these rules by construction: its driver tasks issue each marker and each byte in its own cycle, always in start, bytes, stop order. The one deliberate stress case, a transaction opened during busy and closed after it, stays inside the same rules.

// File: rtl/ctl_guard_pkg.sv
package ctl_guard_pkg;

    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic [1:0] pup;
        logic [1:0] wdog;
        logic       bprot;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{pup: 2'b01, wdog: 2'b11, bprot: 1'b0};

    localparam byte_t ARM_FIRST  = 8'h02;
    localparam byte_t ARM_SECOND = 8'h06;
    localparam logic [2:0] COMMIT_TAG = 3'b001;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ARM_WEL,
        ACT_ARM_RWEL,
        ACT_COMMIT
    } act_e;

    typedef enum logic [1:0] {
        CNT_NONE,
        CNT_ONE,
        CNT_MANY
    } bcount_e;

    function automatic act_e classify(byte_t b, logic wel_q, logic rwel_q);
        act_e a;
        a = ACT_NONE;
        if (rwel_q) begin
            if (b[3:1] == COMMIT_TAG) a = ACT_COMMIT;
        end else if (b == ARM_FIRST) begin
            a = ACT_ARM_WEL;
        end else if (b == ARM_SECOND && wel_q) begin
            a = ACT_ARM_RWEL;
        end
        return a;
    endfunction

    function automatic cfg_t unpack_cfg(byte_t b);
        cfg_t c;
        c.pup   = {b[7], b[0]};
        c.wdog  = b[6:5];
        c.bprot = b[4];
        return c;
    endfunction

endpackage

// File: rtl/ctl_txn_tracker.sv
module ctl_txn_tracker
    import ctl_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy,
    input  logic  txn_start,
    input  logic  txn_stop,
    input  logic  txn_read,
    input  logic  byte_valid,
    input  byte_t byte_data,
    output logic  ack_valid,
    output logic  ack,
    output logic  done_valid,
    output byte_t done_byte
);

    logic    open_q;
    logic    rd_q;
    logic    rej_q;
    bcount_e cnt_q;
    byte_t   held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            rd_q      <= 1'b0;
            rej_q     <= 1'b0;
            cnt_q     <= CNT_NONE;
            held_q    <= '0;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            if (txn_start) begin
                open_q <= 1'b1;
                rd_q   <= txn_read;
                rej_q  <= busy;
                cnt_q  <= CNT_NONE;
            end else if (txn_stop) begin
                open_q <= 1'b0;
            end else if (byte_valid && open_q && !rd_q) begin
                ack_valid <= 1'b1;
                ack       <= !rej_q && (cnt_q == CNT_NONE);
                if (cnt_q == CNT_NONE) begin
                    held_q <= byte_data;
                    cnt_q  <= CNT_ONE;
                end else begin
                    cnt_q  <= CNT_MANY;
                end
            end
        end
    end

    assign done_valid = txn_stop && !txn_start && open_q && !rd_q && !rej_q
                        && (cnt_q == CNT_ONE);
    assign done_byte  = held_q;

    // R7
    ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(byte_valid));

    // R10
    no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && $past(busy)) |-> !ack);

endmodule

// File: rtl/ctl_prog_timer.sv
module ctl_prog_timer #(
    parameter int unsigned PROG_TICKS = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic finish
);

    localparam int unsigned CW = $clog2(PROG_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (launch && !busy) begin
            busy  <= 1'b1;
            cnt_q <= LOAD;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign finish = busy && (cnt_q == '0);

    // R5
    launch_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);

    // R10
    no_launch_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);

endmodule

// File: rtl/ctl_unlock_ctl.sv
module ctl_unlock_ctl
    import ctl_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  done_valid,
    input  byte_t done_byte,
    input  logic  prot_hit,
    input  logic  finish,
    output logic  wel,
    output logic  rwel,
    output cfg_t  cfg,
    output logic  launch
);

    act_e act;

    always_comb begin
        act = ACT_NONE;
        if (done_valid) act = classify(done_byte, wel, rwel);
    end

    assign launch = (act == ACT_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
            cfg  <= CFG_RESET;
        end else begin
            if (finish) begin
                wel  <= 1'b0;
                rwel <= 1'b0;
            end else begin
                unique case (act)
                    ACT_ARM_WEL:  wel <= 1'b1;
                    ACT_ARM_RWEL: begin
                        wel  <= 1'b1;
                        rwel <= 1'b1;
                    end
                    ACT_COMMIT:   cfg <= unpack_cfg(done_byte);
                    default: ;
                endcase
            end
            if (prot_hit) rwel <= 1'b0;
        end
    end

    // R4
    cfg_needs_rwel_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $past(rwel));

    // R3
    rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rwel) |-> wel);

    // R5
    latches_drop_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> (!wel && !rwel));

    // R9
    prot_clears_rwel_chk: assert property (@(posedge clk) disable iff (rst)
        prot_hit |=> !rwel);

endmodule

// File: rtl/ctl_reg_guard.sv
module ctl_reg_guard
    import ctl_guard_pkg::*;
#(
    parameter int unsigned PROG_TICKS = 2_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       txn_start,
    input  logic       txn_stop,
    input  logic       txn_read,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       prot_hit,
    output logic       ack_valid,
    output logic       ack,
    output logic       wel,
    output logic       rwel,
    output logic       busy,
    output logic [1:0] pup_sel,
    output logic [1:0] wdog_sel,
    output logic       bprot
);

    logic  done_valid;
    byte_t done_byte;
    logic  launch;
    logic  finish;
    cfg_t  cfg;

    ctl_txn_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .txn_start  (txn_start),
        .txn_stop   (txn_stop),
        .txn_read   (txn_read),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .ack_valid  (ack_valid),
        .ack        (ack),
        .done_valid (done_valid),
        .done_byte  (done_byte)
    );

    ctl_unlock_ctl u_ulk (
        .clk        (clk),
        .rst        (rst),
        .done_valid (done_valid),
        .done_byte  (done_byte),
        .prot_hit   (prot_hit),
        .finish     (finish),
        .wel        (wel),
        .rwel       (rwel),
        .cfg        (cfg),
        .launch     (launch)
    );

    ctl_prog_timer #(.PROG_TICKS(PROG_TICKS)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (busy),
        .finish (finish)
    );

    assign pup_sel  = cfg.pup;
    assign wdog_sel = cfg.wdog;
    assign bprot    = cfg.bprot;

    // R10
    no_done_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> !busy);

    // R6
    fields_hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $rose(busy));

endmodule

// File: tb/sim_ctl_reg_guard.sv
`timescale 1ns/1ps
module sim_ctl_reg_guard;

    localparam int TICKS = 40;

    typedef struct {
        logic  a;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txn_start = 1'b0;
    logic       txn_stop = 1'b0;
    logic       txn_read = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       prot_hit = 1'b0;
    logic       ack_valid, ack, wel, rwel, busy, bprot;
    logic [1:0] pup_sel, wdog_sel;

    int   checks = 0;
    int   errors = 0;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    ctl_reg_guard #(.PROG_TICKS(TICKS)) u0 (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_stop(txn_stop),
        .txn_read(txn_read), .byte_valid(byte_valid), .byte_data(byte_data),
        .prot_hit(prot_hit), .ack_valid(ack_valid), .ack(ack), .wel(wel),
        .rwel(rwel), .busy(busy), .pup_sel(pup_sel), .wdog_sel(wdog_sel),
        .bprot(bprot)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected responses as the design produces them
    always @(negedge clk) begin
        if (!rst && ack_valid) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected ack_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (ack !== e.a) begin
                    errors++;
                    $display("FAIL %s ack actual=%0b expected=%0b", e.tag, ack, e.a);
                end
            end
        end
    end

    task automatic start_t(input logic rd);
        txn_read = rd; txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0; txn_read = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, input logic resp, input logic e, input string tag);
        if (resp) expq.push_back('{a: e, tag: tag});
        byte_data = b; byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic stop_t();
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
    endtask

    task automatic wr1(input logic [7:0] b, input string tag);
        start_t(1'b0);
        put_byte(b, 1'b1, 1'b1, tag);
        stop_t();
    endtask

    task automatic rd_txn();
        start_t(1'b1);
        put_byte(8'h02, 1'b0, 1'b0, "R8");
        put_byte(8'h55, 1'b0, 1'b0, "R8");
        stop_t();
    endtask

    task automatic chk_cfg(input int p, input int w, input int b, input string tag);
        chk(tag, pup_sel, p, "pup_sel");
        chk(tag, wdog_sel, w, "wdog_sel");
        chk(tag, bprot, b, "bprot");
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_cfg(1, 3, 0, "R1");
        chk("R1", wel, 0, "wel");
        chk("R1", rwel, 0, "rwel");
        chk("R1", busy, 0, "busy");
        chk("R1", ack_valid, 0, "ack_valid");

        // R3: 06h without write enable does nothing
        wr1(8'h06, "R3");
        chk("R3", rwel, 0, "rwel after bare 06h");
        chk("R3", wel, 0, "wel after bare 06h");

        // R2
        wr1(8'h02, "R2");
        chk("R2", wel, 1, "wel after 02h");
        chk("R2", busy, 0, "busy after 02h");

        // R8: read between steps
        rd_txn();
        chk("R8", wel, 1, "wel after read");

        // R3: inexact second byte
        wr1(8'h07, "R3");
        chk("R3", rwel, 0, "rwel after 07h");
        wr1(8'h06, "R3");
        chk("R3", rwel, 1, "rwel after 06h");
        chk("R3", wel, 1, "wel after 06h");

        rd_txn();
        chk("R8", rwel, 1, "rwel after read");

        // R7: second byte NACK, transaction aborted
        start_t(1'b0);
        put_byte(8'hA3, 1'b1, 1'b1, "R7");
        put_byte(8'h55, 1'b1, 1'b0, "R7");
        stop_t();
        chk_cfg(1, 3, 0, "R7");
        chk("R7", busy, 0, "busy after aborted write");
        chk("R7", rwel, 1, "rwel after aborted write");

        // R6: 011 pattern keeps everything
        wr1(8'h06, "R6");
        wr1(8'hF6, "R6");
        chk_cfg(1, 3, 0, "R6");
        chk("R6", rwel, 1, "rwel after F6h");
        chk("R6", busy, 0, "busy after F6h");

        // R4: commit B3h = 1011_0011 -> pup 11, wdog 01, bprot 1
        start_t(1'b0);
        put_byte(8'hB3, 1'b1, 1'b1, "R4");
        @(negedge clk);
        chk_cfg(1, 3, 0, "R4");
        stop_t();
        chk_cfg(3, 1, 1, "R4");
        // R5 busy length
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk("R5", n, TICKS, "busy cycles");
        chk("R5", wel, 0, "wel after busy");
        chk("R5", rwel, 0, "rwel after busy");

        // R11: 02h, 06h, 02h zeroes the fields
        wr1(8'h02, "R11");
        wr1(8'h06, "R11");
        wr1(8'h02, "R11");
        chk_cfg(0, 0, 0, "R11");
        wait_idle();

        // R9
        wr1(8'h02, "R9");
        wr1(8'h06, "R9");
        prot_hit = 1'b1;
        @(negedge clk);
        prot_hit = 1'b0;
        chk("R9", rwel, 0, "rwel after prot_hit");
        chk("R9", wel, 1, "wel after prot_hit");
        wr1(8'hB3, "R9");
        chk_cfg(0, 0, 0, "R9");
        chk("R9", busy, 0, "busy after refused commit");

        // R10: commit 43h, then a transaction opened while busy
        wr1(8'h06, "R10");
        wr1(8'h43, "R10");
        chk("R10", busy, 1, "busy after commit");
        start_t(1'b0);
        put_byte(8'h02, 1'b1, 1'b0, "R10");
        wait_idle();
        stop_t();
        chk("R10", wel, 0, "wel after refused transaction");
        chk_cfg(1, 2, 0, "R10");

        repeat (3) @(negedge clk);
        chk("R7", expq.size(), 0, "responses outstanding");
        finish_run();
    end

endmodule